// File: doc/BRIEF.md
# Configurable Video Output Pixel Formatter

This block sits at the last stage of a display pipeline. It accepts one pixel per clock as three 12-bit colour components (red, green and blue slots) with a data-enable, and turns them into a formatted parallel video word on three output lanes, each 16 bits wide. A colour-format select sets how the three slots are treated: as RGB, or as Y/Cb/Cr with the green slot carrying luma. From that select the block derives, without further input, whether red and blue are swapped at the input, whether luma and chroma are clamped to programmable limits, whether 4:2:2 packing is active and in which order the components leave on the lanes. The block does no matrix conversion: it only interprets the components.

Separate selects choose the luma/chroma interleave layout and the output bit depth. For 4:2:2 output the block sends one luma sample and one chroma sample per pixel, and the chroma sample alternates between Cb and Cr on successive active pixels. The result is registered once, and the data-enable is delayed to match it.

Top module: `vpf_top`

## Requirements
- R1: The outputs come from registers with one cycle of latency: `out_de` equals `in_de` from the previous cycle. While `rst_n` is low, `out_de` and all lanes are zero.
- R2: A cycle in which `out_de` is low has all three output lanes at zero, whatever the inputs were.
- R3: The format select `cfg_fmt` works as follows. Codes 0, 1 and 4 are RGB: no swap, no clamp, no packing, lane order RGB. Code 2 is YCbCr 4:4:4 with clamping, and code 5 is the same without clamping; both force lane order BGR. Code 3 is YCbCr 4:2:2 with clamping, and code 6 is the same without clamping; both turn on packing and the red/blue input swap. Code 7 is raw RGB, the only code that uses `cfg_order`.
- R4: Under code 7, `cfg_order` places the components on lanes d0/d1/d2: 0=R,G,B; 1=G,B,R; 2=B,R,G; 3=R,B,G; 4=G,R,B; 5=B,G,R; 6 and 7 act as 0.
- R5: When clamping is on, the green slot (Y) is clamped to [`lim_y_lo`,`lim_y_hi`] and the red and blue slots (Cr, Cb) to [`lim_c_lo`,`lim_c_hi`]. A value below the bottom limit becomes the bottom limit; otherwise a value above the top limit becomes the top limit. If the limits cross, the bottom limit wins. Values inside the range and on its edges pass unchanged.
- R6: In 4:2:2 modes Cb is taken from `in_r` and Cr from `in_b`. The chroma sample is Cb on the first active pixel after `in_de` rises and then alternates Cr, Cb, ... on each further active pixel.
- R7: `cfg_ilv` sets the lane layout. 0 means no interleave (permuted triplet). 3 (CY) gives d0=chroma, d1=Y. 4 (YC) gives d0=Y, d1=chroma. In both of these d2 is zero. Codes 5 to 7 act as 0, and packing with code 0 acts as 4. Without packing, the chroma sample is the blue slot.
- R8: `cfg_ilv` 1 (CYCY) and 2 (YCYC) put a single stream on d0, alternating by pixel phase. Mode 1 sends chroma on even-phase pixels and Y on odd ones; mode 2 does the opposite. d1 and d2 stay zero.
- R9: `cfg_depth` sets the lane format: 0=8 bits (component >>4, right-aligned), 1=10 bits (>>2), 2=12 bits (as is), 3=16 bits (component <<4, low bits zero).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_de | input | 1 | Input data-enable, high for an active pixel |
| in_r | input | 12 | Red slot (Cr, or Cb in 4:2:2) |
| in_g | input | 12 | Green slot (Y) |
| in_b | input | 12 | Blue slot (Cb, or Cr in 4:2:2) |
| cfg_fmt | input | 3 | Colour-format select |
| cfg_order | input | 3 | Lane permutation for raw format |
| cfg_ilv | input | 3 | Luma/chroma interleave layout |
| cfg_depth | input | 2 | Output bit-depth select |
| lim_y_lo | input | 12 | Luma bottom limit |
| lim_y_hi | input | 12 | Luma top limit |
| lim_c_lo | input | 12 | Chroma bottom limit |
| lim_c_hi | input | 12 | Chroma top limit |
| out_de | output | 1 | Delayed data-enable |
| out_d0 | output | 16 | Output lane 0 |
| out_d1 | output | 16 | Output lane 1 |
| out_d2 | output | 16 | Output lane 2 |

## Verification
The assertions check on every cycle the data-enable delay, zero lanes during blanking, the zero lanes of the sequential and two-lane interleave layouts, the unused bits that each depth setting leaves, and the luma range of clamped 4:4:4 output. Other behaviour depends on sequence and value, and only the bench scenarios show it: the Cb/Cr alternation and its restart when data-enable rises, the six permutations, the priority of the bottom limit when the limits cross, and the exact lane values for each format.

// File: rtl/vpf_pkg.sv
`timescale 1ns/1ps
package vpf_pkg;

  localparam logic [2:0] FMT_RGB       = 3'd0;
  localparam logic [2:0] FMT_RGB_FULL  = 3'd1;
  localparam logic [2:0] FMT_Y444      = 3'd2;
  localparam logic [2:0] FMT_Y422      = 3'd3;
  localparam logic [2:0] FMT_XV        = 3'd4;
  localparam logic [2:0] FMT_Y444_FULL = 3'd5;
  localparam logic [2:0] FMT_Y422_FULL = 3'd6;
  localparam logic [2:0] FMT_RAW       = 3'd7;

  localparam logic [2:0] ORD_RGB = 3'd0;
  localparam logic [2:0] ORD_BGR = 3'd5;

  localparam logic [2:0] ILV_NONE = 3'd0;
  localparam logic [2:0] ILV_CYCY = 3'd1;
  localparam logic [2:0] ILV_YCYC = 3'd2;
  localparam logic [2:0] ILV_CY   = 3'd3;
  localparam logic [2:0] ILV_YC   = 3'd4;

  localparam int NLANE = 3;

  typedef struct packed {
    logic       pack;
    logic       clamp;
    logic       rbswap;
    logic [2:0] order;
  } vpf_ctrl_t;

endpackage

// File: rtl/vpf_fmt_decode.sv
`timescale 1ns/1ps
module vpf_fmt_decode
  import vpf_pkg::*;
(
  input  logic [2:0] fmt,
  input  logic [2:0] order_sel,
  output vpf_ctrl_t  ctrl
);

  always_comb begin
    ctrl.pack   = 1'b0;
    ctrl.clamp  = 1'b0;
    ctrl.rbswap = 1'b0;
    ctrl.order  = ORD_RGB;
    case (fmt)
      FMT_Y444: begin
        ctrl.clamp = 1'b1;
        ctrl.order = ORD_BGR;
      end
      FMT_Y444_FULL: ctrl.order = ORD_BGR;
      FMT_Y422: begin
        ctrl.pack   = 1'b1;
        ctrl.clamp  = 1'b1;
        ctrl.rbswap = 1'b1;
      end
      FMT_Y422_FULL: begin
        ctrl.pack   = 1'b1;
        ctrl.rbswap = 1'b1;
      end
      FMT_RAW: ctrl.order = order_sel;
      default: ctrl.order = ORD_RGB;
    endcase
  end

endmodule

// File: rtl/vpf_clamp.sv
`timescale 1ns/1ps
module vpf_clamp #(
  parameter int W = 12
) (
  input  logic         en,
  input  logic [W-1:0] x,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] hi,
  output logic [W-1:0] y
);

  always_comb begin
    y = x;
    if (en) begin
      if (x < lo)      y = lo;
      else if (x > hi) y = hi;
    end
  end

endmodule

// File: rtl/vpf_lane_select.sv
`timescale 1ns/1ps
module vpf_lane_select
  import vpf_pkg::*;
#(
  parameter int W = 12
) (
  input  logic [W-1:0]             cr,
  input  logic [W-1:0]             cy,
  input  logic [W-1:0]             cb,
  input  logic                     pack,
  input  logic                     phase,
  input  logic [2:0]               order,
  input  logic [2:0]               ilv,
  output logic [NLANE-1:0][W-1:0]  lane
);

  logic [2:0]   ilv_eff;
  logic [W-1:0] chroma;

  always_comb begin
    ilv_eff = (ilv > ILV_YC) ? ILV_NONE : ilv;
    if (pack && (ilv_eff == ILV_NONE)) ilv_eff = ILV_YC;
    chroma = (pack && phase) ? cr : cb;
  end

  always_comb begin
    lane = '0;
    case (ilv_eff)
      ILV_CYCY: lane[0] = phase ? cy : chroma;
      ILV_YCYC: lane[0] = phase ? chroma : cy;
      ILV_CY: begin
        lane[0] = chroma;
        lane[1] = cy;
      end
      ILV_YC: begin
        lane[0] = cy;
        lane[1] = chroma;
      end
      default: begin
        case (order)
          3'd1:    begin lane[0] = cy; lane[1] = cb; lane[2] = cr; end
          3'd2:    begin lane[0] = cb; lane[1] = cr; lane[2] = cy; end
          3'd3:    begin lane[0] = cr; lane[1] = cb; lane[2] = cy; end
          3'd4:    begin lane[0] = cy; lane[1] = cr; lane[2] = cb; end
          3'd5:    begin lane[0] = cb; lane[1] = cy; lane[2] = cr; end
          default: begin lane[0] = cr; lane[1] = cy; lane[2] = cb; end
        endcase
      end
    endcase
  end

endmodule

// File: rtl/vpf_depth.sv
`timescale 1ns/1ps
module vpf_depth #(
  parameter int CW = 12,
  parameter int OW = 16
) (
  input  logic [CW-1:0] x,
  input  logic [1:0]    depth,
  output logic [OW-1:0] y
);

  logic [OW-1:0] ext;
  int            nbits;

  always_comb begin
    ext = OW'(x);
    case (depth)
      2'd0:    nbits = 8;
      2'd1:    nbits = 10;
      2'd2:    nbits = 12;
      default: nbits = 16;
    endcase
    if (nbits <= CW) y = ext >> (CW - nbits);
    else             y = ext << (nbits - CW);
  end

endmodule

// File: rtl/vpf_top.sv
`timescale 1ns/1ps
module vpf_top
  import vpf_pkg::*;
#(
  parameter int CW = 12,
  parameter int OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_de,
  input  logic [CW-1:0] in_r,
  input  logic [CW-1:0] in_g,
  input  logic [CW-1:0] in_b,
  input  logic [2:0]    cfg_fmt,
  input  logic [2:0]    cfg_order,
  input  logic [2:0]    cfg_ilv,
  input  logic [1:0]    cfg_depth,
  input  logic [CW-1:0] lim_y_lo,
  input  logic [CW-1:0] lim_y_hi,
  input  logic [CW-1:0] lim_c_lo,
  input  logic [CW-1:0] lim_c_hi,
  output logic          out_de,
  output logic [OW-1:0] out_d0,
  output logic [OW-1:0] out_d1,
  output logic [OW-1:0] out_d2
);

  vpf_ctrl_t ctrl;

  vpf_fmt_decode u_dec (
    .fmt       (cfg_fmt),
    .order_sel (cfg_order),
    .ctrl      (ctrl)
  );

  // slot 0 = red/Cr, slot 1 = green/Y, slot 2 = blue/Cb after the input swap
  logic [NLANE-1:0][CW-1:0] slot_raw, slot_lo, slot_hi, slot_cl;

  always_comb begin
    slot_raw[0] = ctrl.rbswap ? in_b : in_r;
    slot_raw[1] = in_g;
    slot_raw[2] = ctrl.rbswap ? in_r : in_b;
    slot_lo[0]  = lim_c_lo;
    slot_hi[0]  = lim_c_hi;
    slot_lo[1]  = lim_y_lo;
    slot_hi[1]  = lim_y_hi;
    slot_lo[2]  = lim_c_lo;
    slot_hi[2]  = lim_c_hi;
  end

  for (genvar i = 0; i < NLANE; i++) begin : g_clamp
    vpf_clamp #(.W(CW)) u_clamp (
      .en (ctrl.clamp),
      .x  (slot_raw[i]),
      .lo (slot_lo[i]),
      .hi (slot_hi[i]),
      .y  (slot_cl[i])
    );
  end

  // chroma phase: restarts at the first active pixel of every enable run
  logic de_q, phase_q, phase_cur, phase_nxt, phase_en;

  always_comb begin
    phase_cur = de_q ? phase_q : 1'b0;
    phase_en  = in_de;
    phase_nxt = ~phase_cur;
  end

  logic [NLANE-1:0][CW-1:0] lane_c;

  vpf_lane_select #(.W(CW)) u_sel (
    .cr    (slot_cl[0]),
    .cy    (slot_cl[1]),
    .cb    (slot_cl[2]),
    .pack  (ctrl.pack),
    .phase (phase_cur),
    .order (ctrl.order),
    .ilv   (cfg_ilv),
    .lane  (lane_c)
  );

  logic [NLANE-1:0][OW-1:0] lane_w, lane_nxt, lane_q;

  for (genvar i = 0; i < NLANE; i++) begin : g_depth
    vpf_depth #(.CW(CW), .OW(OW)) u_depth (
      .x     (lane_c[i]),
      .depth (cfg_depth),
      .y     (lane_w[i])
    );
  end

  always_comb begin
    lane_nxt = in_de ? lane_w : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q    <= 1'b0;
      phase_q <= 1'b0;
      lane_q  <= '0;
    end else begin
      de_q   <= in_de;
      lane_q <= lane_nxt;
      if (phase_en) phase_q <= phase_nxt;
    end
  end

  assign out_de = de_q;
  assign out_d0 = lane_q[0];
  assign out_d1 = lane_q[1];
  assign out_d2 = lane_q[2];

endmodule

// File: rtl/vpf_checker.sv
`timescale 1ns/1ps
module vpf_checker #(
  parameter int CW = 12,
  parameter int OW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_de,
  input logic [2:0]    cfg_fmt,
  input logic [2:0]    cfg_ilv,
  input logic [1:0]    cfg_depth,
  input logic [CW-1:0] lim_y_lo,
  input logic [CW-1:0] lim_y_hi,
  input logic          out_de,
  input logic [OW-1:0] out_d0,
  input logic [OW-1:0] out_d1,
  input logic [OW-1:0] out_d2
);

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  a_r1_de_delay: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (out_de == $past(in_de)));

  // R2
  a_r2_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_de |-> (out_d0 == '0 && out_d1 == '0 && out_d2 == '0));

  // R8
  a_r8_seq_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_de && (cfg_ilv == 3'd1 || cfg_ilv == 3'd2)))
      |-> (out_d1 == '0 && out_d2 == '0));

  // R7
  a_r7_two_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_de && (cfg_ilv == 3'd3 || cfg_ilv == 3'd4)))
      |-> (out_d2 == '0));

  // R9
  a_r9_depth8_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cfg_depth == 2'd0))
      |-> ((out_d0 >> 8) == '0 && (out_d1 >> 8) == '0 && (out_d2 >> 8) == '0));

  // R9
  a_r9_depth16_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cfg_depth == 2'd3))
      |-> (out_d0[3:0] == 4'h0 && out_d1[3:0] == 4'h0 && out_d2[3:0] == 4'h0));

  // R5: luma lands on d1 for clamped 4:4:4 at 12 bits
  a_r5_luma_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(in_de && cfg_fmt == 3'd2 && cfg_ilv == 3'd0 &&
                      cfg_depth == 2'd2 && lim_y_lo <= lim_y_hi))
      |-> (out_d1 >= OW'($past(lim_y_lo)) && out_d1 <= OW'($past(lim_y_hi))));

endmodule

bind vpf_top vpf_checker #(.CW(CW), .OW(OW)) u_vpf_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_de     (in_de),
  .cfg_fmt   (cfg_fmt),
  .cfg_ilv   (cfg_ilv),
  .cfg_depth (cfg_depth),
  .lim_y_lo  (lim_y_lo),
  .lim_y_hi  (lim_y_hi),
  .out_de    (out_de),
  .out_d0    (out_d0),
  .out_d1    (out_d1),
  .out_d2    (out_d2)
);

// File: tb/vpf_top_tb_top.sv
`timescale 1ns/1ps
module vpf_top_tb_top;

  logic        clk, rst_n, in_de;
  logic [11:0] in_r, in_g, in_b;
  logic [2:0]  cfg_fmt, cfg_order, cfg_ilv;
  logic [1:0]  cfg_depth;
  logic [11:0] lim_y_lo, lim_y_hi, lim_c_lo, lim_c_hi;
  logic        out_de;
  logic [15:0] out_d0, out_d1, out_d2;

  int checks = 0;
  int fails  = 0;

  vpf_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_de(in_de),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .cfg_fmt(cfg_fmt), .cfg_order(cfg_order), .cfg_ilv(cfg_ilv),
    .cfg_depth(cfg_depth),
    .lim_y_lo(lim_y_lo), .lim_y_hi(lim_y_hi),
    .lim_c_lo(lim_c_lo), .lim_c_hi(lim_c_hi),
    .out_de(out_de), .out_d0(out_d0), .out_d1(out_d1), .out_d2(out_d2)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [2:0]  fmt;
    logic [2:0]  ord;
    logic [2:0]  ilv;
    logic [1:0]  dep;
    logic [11:0] r;
    logic [11:0] g;
    logic [11:0] b;
    logic [15:0] e0;
    logic [15:0] e1;
    logic [15:0] e2;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 3'd0, 3'd0, 2'd2, 12'h123, 12'h456, 12'h789, 16'h0123, 16'h0456, 16'h0789}, // R3 rgb
    '{3'd0, 3'd0, 3'd0, 2'd0, 12'h123, 12'h456, 12'h789, 16'h0012, 16'h0045, 16'h0078}, // R9 8b
    '{3'd0, 3'd0, 3'd0, 2'd1, 12'h123, 12'h456, 12'h789, 16'h0048, 16'h0115, 16'h01E2}, // R9 10b
    '{3'd0, 3'd0, 3'd0, 2'd3, 12'h123, 12'h456, 12'h789, 16'h1230, 16'h4560, 16'h7890}, // R9 16b
    '{3'd7, 3'd1, 3'd0, 2'd2, 12'h123, 12'h456, 12'h789, 16'h0456, 16'h0789, 16'h0123}, // R4 GBR
    '{3'd7, 3'd2, 3'd0, 2'd2, 12'h123, 12'h456, 12'h789, 16'h0789, 16'h0123, 16'h0456}, // R4 BRG
    '{3'd7, 3'd3, 3'd0, 2'd2, 12'h123, 12'h456, 12'h789, 16'h0123, 16'h0789, 16'h0456}, // R4 RBG
    '{3'd7, 3'd4, 3'd0, 2'd2, 12'h123, 12'h456, 12'h789, 16'h0456, 16'h0123, 16'h0789}, // R4 GRB
    '{3'd7, 3'd5, 3'd0, 2'd2, 12'h123, 12'h456, 12'h789, 16'h0789, 16'h0456, 16'h0123}, // R4 BGR
    '{3'd0, 3'd5, 3'd0, 2'd2, 12'h123, 12'h456, 12'h789, 16'h0123, 16'h0456, 16'h0789}, // R3 order ignored
    '{3'd2, 3'd0, 3'd0, 2'd2, 12'h005, 12'hFF0, 12'h800, 16'h0800, 16'h0FE0, 16'h0010}, // R5 444 clamp
    '{3'd5, 3'd0, 3'd0, 2'd2, 12'h005, 12'hFF0, 12'h800, 16'h0800, 16'h0FF0, 16'h0005}, // R3 444 full
    '{3'd1, 3'd0, 3'd0, 2'd2, 12'h005, 12'hFF0, 12'h800, 16'h0005, 16'h0FF0, 16'h0800}, // R3 rgb full
    '{3'd4, 3'd0, 3'd0, 2'd2, 12'h005, 12'hFF0, 12'h800, 16'h0005, 16'h0FF0, 16'h0800}, // R3 code 4
    '{3'd3, 3'd0, 3'd0, 2'd2, 12'h005, 12'h300, 12'h900, 16'h0300, 16'h0010, 16'h0000}, // R6 422 clamp
    '{3'd6, 3'd0, 3'd0, 2'd2, 12'h005, 12'h300, 12'h900, 16'h0300, 16'h0005, 16'h0000}, // R6 422 full
    '{3'd0, 3'd0, 3'd3, 2'd2, 12'h123, 12'h456, 12'h789, 16'h0789, 16'h0456, 16'h0000}, // R7 CY
    '{3'd0, 3'd0, 3'd4, 2'd2, 12'h123, 12'h456, 12'h789, 16'h0456, 16'h0789, 16'h0000}, // R7 YC
    '{3'd0, 3'd0, 3'd1, 2'd2, 12'h123, 12'h456, 12'h789, 16'h0789, 16'h0000, 16'h0000}, // R8 CYCY even
    '{3'd0, 3'd0, 3'd2, 2'd2, 12'h123, 12'h456, 12'h789, 16'h0456, 16'h0000, 16'h0000}, // R8 YCYC even
    '{3'd0, 3'd0, 3'd6, 2'd2, 12'h123, 12'h456, 12'h789, 16'h0123, 16'h0456, 16'h0789}, // R7 code 6
    '{3'd3, 3'd0, 3'd3, 2'd2, 12'h005, 12'h300, 12'h900, 16'h0010, 16'h0300, 16'h0000}, // R7 CY packed
    '{3'd2, 3'd0, 3'd0, 2'd0, 12'h005, 12'hFF0, 12'h800, 16'h0080, 16'h00FE, 16'h0001}  // R9 8b clamp
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(input logic de, input logic [11:0] r, input logic [11:0] g,
                       input logic [11:0] b);
    in_de = de; in_r = r; in_g = g; in_b = b;
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b1, 12'hAAA, 12'hBBB, 12'hCCC);
    cfg_fmt = 3'd0; cfg_order = 3'd0; cfg_ilv = 3'd0; cfg_depth = 2'd2;
    lim_y_lo = 12'h010; lim_y_hi = 12'hFE0; lim_c_lo = 12'h010; lim_c_hi = 12'hFE0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset de", {15'd0, out_de}, 16'h0);
    chk("R1 reset d0", out_d0, 16'h0);
    chk("R1 reset d2", out_d2, 16'h0);
    drive(1'b0, 12'h0, 12'h0, 12'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: each vector is an isolated one-pixel enable pulse
    for (int i = 0; i < NV; i++) begin
      cfg_fmt = VEC[i].fmt; cfg_order = VEC[i].ord;
      cfg_ilv = VEC[i].ilv; cfg_depth = VEC[i].dep;
      drive(1'b1, VEC[i].r, VEC[i].g, VEC[i].b);
      @(negedge clk);
      chk($sformatf("R1 vec%0d de", i), {15'd0, out_de}, 16'h1);
      chk($sformatf("R3/R4/R5/R7/R8/R9 vec%0d d0", i), out_d0, VEC[i].e0);
      chk($sformatf("R3/R4/R5/R7/R8/R9 vec%0d d1", i), out_d1, VEC[i].e1);
      chk($sformatf("R3/R4/R5/R7/R8/R9 vec%0d d2", i), out_d2, VEC[i].e2);
      drive(1'b0, 12'hFFF, 12'hFFF, 12'hFFF);
      @(negedge clk);
    end

    // R2: blanking with nonzero inputs
    chk("R2 blank de", {15'd0, out_de}, 16'h0);
    chk("R2 blank d0", out_d0, 16'h0);
    chk("R2 blank d1", out_d1, 16'h0);

    // R6: Cb/Cr alternation over a 3-pixel run, then restart
    cfg_fmt = 3'd3; cfg_ilv = 3'd0; cfg_depth = 2'd2;
    for (int k = 0; k < 3; k++) begin
      drive(1'b1, 12'h100 + 12'(k * 16), 12'h300 + 12'(k * 16), 12'h200 + 12'(k * 16));
      @(negedge clk);
      chk($sformatf("R6 run pix%0d Y", k), out_d0, 16'h0300 + 16'(k * 16));
      chk($sformatf("R6 run pix%0d C", k), out_d1,
          (k % 2 == 0) ? 16'h0100 + 16'(k * 16) : 16'h0200 + 16'(k * 16));
    end
    drive(1'b0, 12'h0, 12'h0, 12'h0);
    @(negedge clk);
    drive(1'b1, 12'h155, 12'h355, 12'h255);
    @(negedge clk);
    chk("R6 restart gives Cb", out_d1, 16'h0155);
    drive(1'b1, 12'h166, 12'h366, 12'h266);
    @(negedge clk);
    chk("R6 second gives Cr", out_d1, 16'h0266);

    // R8: CYCY on an odd-phase pixel sends Y
    cfg_fmt = 3'd0; cfg_ilv = 3'd1;
    drive(1'b0, 12'h0, 12'h0, 12'h0);
    @(negedge clk);
    drive(1'b1, 12'h111, 12'h222, 12'h333);
    @(negedge clk);
    chk("R8 CYCY even chroma", out_d0, 16'h0333);
    drive(1'b1, 12'h111, 12'h444, 12'h333);
    @(negedge clk);
    chk("R8 CYCY odd luma", out_d0, 16'h0444);

    // R5: crossed chroma limits, bottom wins; luma on edge passes
    cfg_fmt = 3'd2; cfg_ilv = 3'd0;
    lim_c_lo = 12'h400; lim_c_hi = 12'h300;
    drive(1'b1, 12'h350, 12'h010, 12'h500);
    @(negedge clk);
    chk("R5 crossed below lo", out_d2, 16'h0400);
    chk("R5 crossed above hi", out_d0, 16'h0300);
    chk("R5 luma on edge", out_d1, 16'h0010);
    drive(1'b0, 12'h0, 12'h0, 12'h0);
    @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule